// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the pixel and line counters of a raster display. From them it derives horizontal and vertical blanking, horizontal and vertical sync, and a display-enable flag. Software programs each axis through a write-only register port. Every timing register carries two interval boundaries, and each boundary is stored as its count minus one. A line, and likewise a frame, runs as active region, front porch, sync pulse and back porch. Blanking begins where the active region ends and lasts until the total.

The register port is guarded by a key. A write of the key to the key register opens the port, and a write of any other value closes it again. While the port is closed, writes to every other register are discarded. Timing writes go into a shadow set. The live set is refreshed from the shadow set at the first pixel of each new frame, or on every cycle while the generator is disabled. A frame that is in progress therefore never mixes two modes.

Top module: `raster_tgen_top`

## Requirements
- R1: After a synchronous active-low reset, the port is closed, the generator is off, every timing field is zero, `pix_x_o` and `line_y_o` are 0, `de_o`, `hsync_o` and `vsync_o` are 0, and `hblank_o` and `vblank_o` are 1.
- R2: The register addresses are: 0 key, 1 configuration, 2 horizontal active/total, 3 horizontal blank start/end, 4 horizontal sync start/end, and 5 to 7 the same three for the vertical axis. In each timing register, bits 15:0 hold the first value minus one and bits 31:16 hold the second value minus one.
- R3: A write to address 0 opens the port if the data equals 32'h0000_4758 and closes it for any other value. While the port is closed, writes to addresses 1 to 7 change nothing that is visible at the outputs.
- R4: While enabled, `pix_x_o` counts 0 to htotal-1 once per clock and then wraps. At each wrap, `line_y_o` advances by one, and it wraps after vtotal-1.
- R5: `de_o` is 1 exactly when the generator is enabled, `pix_x_o` < hactive and `line_y_o` < vactive.
- R6: `hblank_o` is 1 when `pix_x_o` lies in [hblank start, hblank end-1] or the generator is off. `vblank_o` follows the same rule for `line_y_o` with the vertical values.
- R7: Before inversion, `hsync_o` is 1 while enabled and `pix_x_o` lies in [hsync start, hsync end-1]. Vertical sync follows the same rule in lines.
- R8: Configuration bit 1 inverts `hsync_o` and bit 2 inverts `vsync_o`. The inactive level of each sync is its inversion bit.
- R9: Configuration bit 0 enables the generator. The clock edge that writes 0 to it still steps the counters, and the edge after that returns them to 0. While the bit is 0, `de_o` is 0, both blanks are 1 and both syncs sit at their inactive level.
- R10: Timing written while the generator runs takes effect at the clock edge that wraps both counters to 0. Timing written while it is off is in force from the first enabled cycle.
- R11: A configuration write changes the enable and inversion outputs from the cycle that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| de_o | output | 1 | Display enable |
| pix_x_o | output | CNT_W | Current pixel in the line |
| line_y_o | output | CNT_W | Current line in the frame |

## Verification
On every cycle, the assertions check that each counter steps by one, wraps to zero at its total and never exceeds it. They also check that the line number holds between horizontal wraps, that closed-port writes leave the shadow set and configuration untouched, and that the live timing set changes only at a frame boundary or while the generator is off. Only the bench scenarios can show the shapes of the blank, sync and enable windows for a programmed mode, the effect of the key sequence, and the frame on which a new mode first appears, because these depend on register contents written in sequence.

// File: rtl/vtg_pkg.sv
// Shared types for the raster timing generator.
// Assumes a 32-bit register word split into two 16-bit halves.
package vtg_pkg;
    localparam int HALF_W = 16;
    localparam int REG_W  = 32;

    // One axis worth of boundaries, each held as count minus one.
    typedef struct packed {
        logic [HALF_W-1:0] act_m1;
        logic [HALF_W-1:0] tot_m1;
        logic [HALF_W-1:0] bst_m1;
        logic [HALF_W-1:0] bend_m1;
        logic [HALF_W-1:0] sst_m1;
        logic [HALF_W-1:0] send_m1;
    } axis_tim_t;

    typedef enum logic [2:0] {
        A_KEY  = 3'd0,
        A_CFG  = 3'd1,
        A_HACT = 3'd2,
        A_HBLK = 3'd3,
        A_HSYN = 3'd4,
        A_VACT = 3'd5,
        A_VBLK = 3'd6,
        A_VSYN = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/vtg_regs.sv
// Key-guarded register file with a shadow and a live timing set.
// Assumes the key register is always writable. All other writes are
// dropped while the port is closed. The live set copies the shadow set
// whenever load_i is high.
module vtg_regs
    import vtg_pkg::*;
#(
    parameter logic [REG_W-1:0] UNLOCK_KEY = 32'h0000_4758
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             load_i,
    output axis_tim_t        h_tim_o,
    output axis_tim_t        v_tim_o,
    output logic             en_o,
    output logic             hinv_o,
    output logic             vinv_o
);
    logic              open_q;
    logic [2:0]        cfg_q;
    axis_tim_t         pend_q [2];
    axis_tim_t         live_q [2];
    logic [HALF_W-1:0] lo_w;
    logic [HALF_W-1:0] hi_w;
    logic              wr_ok_w;

    assign lo_w    = wr_data_i[HALF_W-1:0];
    assign hi_w    = wr_data_i[REG_W-1:HALF_W];
    assign wr_ok_w = wr_en_i && open_q && (reg_addr_e'(wr_addr_i) != A_KEY);

    // Key register: opens on the key, closes on any other value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (wr_en_i && reg_addr_e'(wr_addr_i) == A_KEY) begin
            open_q <= (wr_data_i == UNLOCK_KEY);
        end
    end

    // Accepted writes land in the configuration bits or the shadow set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            pend_q[0] <= '0;
            pend_q[1] <= '0;
        end else if (wr_ok_w) begin
            case (reg_addr_e'(wr_addr_i))
                A_CFG:  cfg_q <= wr_data_i[2:0];
                A_HACT: begin pend_q[0].act_m1 <= lo_w; pend_q[0].tot_m1  <= hi_w; end
                A_HBLK: begin pend_q[0].bst_m1 <= lo_w; pend_q[0].bend_m1 <= hi_w; end
                A_HSYN: begin pend_q[0].sst_m1 <= lo_w; pend_q[0].send_m1 <= hi_w; end
                A_VACT: begin pend_q[1].act_m1 <= lo_w; pend_q[1].tot_m1  <= hi_w; end
                A_VBLK: begin pend_q[1].bst_m1 <= lo_w; pend_q[1].bend_m1 <= hi_w; end
                A_VSYN: begin pend_q[1].sst_m1 <= lo_w; pend_q[1].send_m1 <= hi_w; end
                default: ;
            endcase
        end
    end

    // Live set follows the shadow set only at frame start or while off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q[0] <= '0;
            live_q[1] <= '0;
        end else if (load_i) begin
            live_q[0] <= pend_q[0];
            live_q[1] <= pend_q[1];
        end
    end

    assign h_tim_o = live_q[0];
    assign v_tim_o = live_q[1];
    assign en_o    = cfg_q[0];
    assign hinv_o  = cfg_q[1];
    assign vinv_o  = cfg_q[2];

    // R3: a write to a closed port leaves the shadow set and configuration alone
    p_locked_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_q && wr_en_i && reg_addr_e'(wr_addr_i) != A_KEY) |=>
        (pend_q[0] == $past(pend_q[0]) && pend_q[1] == $past(pend_q[1])
         && cfg_q == $past(cfg_q)));

    // R10: the live set moves only on a load request
    p_live_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (live_q[0] == $past(live_q[0]) && live_q[1] == $past(live_q[1])));
endmodule

// File: rtl/vtg_axis.sv
// One counting axis: counts on step_i and wraps at the total. It flags
// the active, blank and sync windows. Assumes boundaries are held as
// count minus one and that the total fits in CNT_W bits.
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             step_i,
    input  axis_tim_t        tim_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             end_o,
    output logic             act_o,
    output logic             blank_o,
    output logic             sync_o
);
    logic [CNT_W-1:0]  cnt_q;
    logic [HALF_W-1:0] cnt_ext;

    assign cnt_ext = HALF_W'(cnt_q);

    // Counter: cleared while stopped, stepped and wrapped while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= end_o ? '0 : cnt_q + 1'b1;
        end
    end

    // Window decode against the live boundaries.
    always_comb begin
        end_o   = (cnt_ext == tim_i.tot_m1);
        act_o   = (cnt_ext <= tim_i.act_m1);
        blank_o = (cnt_ext > tim_i.bst_m1) && (cnt_ext <= tim_i.bend_m1);
        sync_o  = (cnt_ext > tim_i.sst_m1) && (cnt_ext <= tim_i.send_m1);
    end

    assign cnt_o = cnt_q;

    // R4: a running step below the total advances by exactly one
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && step_i && !end_o) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R4: a step at the total returns the counter to zero
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && step_i && end_o) |=> (cnt_o == '0));

    // R4: without a step the count holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !step_i) |=> $stable(cnt_o));

    // R4: a running counter never passes the programmed total
    p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_ext <= tim_i.tot_m1));
endmodule

// File: rtl/raster_tgen_top.sv
// Raster timing generator top. Joins the register file to a horizontal
// and a vertical axis. The vertical axis steps on each horizontal wrap.
// A frame boundary, or the generator being off, refreshes the live timing.
module raster_tgen_top
    import vtg_pkg::*;
#(
    parameter int               CNT_W      = 12,
    parameter logic [REG_W-1:0] UNLOCK_KEY = 32'h0000_4758
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [31:0]      wr_data_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             hblank_o,
    output logic             vblank_o,
    output logic             de_o,
    output logic [CNT_W-1:0] pix_x_o,
    output logic [CNT_W-1:0] line_y_o
);
    localparam int N_AX = 2;

    axis_tim_t        tim_w [N_AX];
    logic [CNT_W-1:0] cnt_w [N_AX];
    logic [N_AX-1:0]  step_w, end_w, act_w, blank_w, sync_w;
    logic             en_w, hinv_w, vinv_w, frame_end_w, load_w;

    vtg_regs #(.UNLOCK_KEY(UNLOCK_KEY)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .load_i    (load_w),
        .h_tim_o   (tim_w[0]),
        .v_tim_o   (tim_w[1]),
        .en_o      (en_w),
        .hinv_o    (hinv_w),
        .vinv_o    (vinv_w)
    );

    // Horizontal steps every clock; vertical steps on the horizontal wrap.
    assign step_w[0] = 1'b1;
    assign step_w[1] = end_w[0];

    for (genvar g = 0; g < N_AX; g++) begin : g_axis
        vtg_axis #(.CNT_W(CNT_W)) u_axis (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_i   (en_w),
            .step_i  (step_w[g]),
            .tim_i   (tim_w[g]),
            .cnt_o   (cnt_w[g]),
            .end_o   (end_w[g]),
            .act_o   (act_w[g]),
            .blank_o (blank_w[g]),
            .sync_o  (sync_w[g])
        );
    end

    assign frame_end_w = en_w && end_w[0] && end_w[1];
    assign load_w      = !en_w || frame_end_w;

    // Output gating by the enable bit and the per-axis polarity.
    always_comb begin
        hsync_o  = (en_w && sync_w[0]) ^ hinv_w;
        vsync_o  = (en_w && sync_w[1]) ^ vinv_w;
        hblank_o = !en_w || blank_w[0];
        vblank_o = !en_w || blank_w[1];
        de_o     = en_w && act_w[0] && act_w[1];
    end

    assign pix_x_o  = cnt_w[0];
    assign line_y_o = cnt_w[1];

    // R4: the line number holds unless the pixel counter wraps
    p_line_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w && !end_w[0]) |=> $stable(line_y_o));
endmodule

// File: tb/raster_tgen_top_tb_top.sv
// Directed bench: one task per scenario, checked against a cycle model.
module raster_tgen_top_tb_top;
    localparam int CNT_W = 12;
    localparam logic [31:0] KEY = 32'h0000_4758;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [2:0]       wr_addr_i = '0;
    logic [31:0]      wr_data_i = '0;
    logic             hsync_o, vsync_o, hblank_o, vblank_o, de_o;
    logic [CNT_W-1:0] pix_x_o, line_y_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Model state: counts (decoded, +1) per register, position, configuration.
    int  p_lo [8];
    int  p_hi [8];
    int  l_lo [8];
    int  l_hi [8];
    int  m_x = 0, m_y = 0;
    bit  m_en = 0, m_hi = 0, m_vi = 0, m_open = 0;

    raster_tgen_top #(.CNT_W(CNT_W), .UNLOCK_KEY(KEY)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .hblank_o(hblank_o), .vblank_o(vblank_o), .de_o(de_o),
        .pix_x_o(pix_x_o), .line_y_o(line_y_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog got %0d cycles exp fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input string req, input string what,
                       input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s %s got %0d exp %0d", tag, req, what, got, exp);
        end
    endtask

    // Compare every output with the model at the current cycle.
    task automatic check_all(input string tag);
        bit e_de, e_hb, e_vb, e_hs, e_vs;
        e_de = m_en && m_x < l_lo[2] && m_y < l_lo[5];
        e_hb = !m_en || (m_x >= l_lo[3] && m_x < l_hi[3]);
        e_vb = !m_en || (m_y >= l_lo[6] && m_y < l_hi[6]);
        e_hs = (m_en && m_x >= l_lo[4] && m_x < l_hi[4]) ^ m_hi;
        e_vs = (m_en && m_y >= l_lo[7] && m_y < l_hi[7]) ^ m_vi;
        chk(tag, "R4", "pix_x", int'(pix_x_o), m_x);
        chk(tag, "R4", "line_y", int'(line_y_o), m_y);
        chk(tag, "R5", "de", int'(de_o), int'(e_de));
        chk(tag, "R6", "hblank", int'(hblank_o), int'(e_hb));
        chk(tag, "R6", "vblank", int'(vblank_o), int'(e_vb));
        chk(tag, "R7", "hsync", int'(hsync_o), int'(e_hs));
        chk(tag, "R7", "vsync", int'(vsync_o), int'(e_vs));
    endtask

    // One clock: counters and live load use old state, then the write applies.
    task automatic tick();
        @(posedge clk);
        if (m_en) begin
            if (m_x == l_hi[2] - 1) begin
                m_x = 0;
                if (m_y == l_hi[5] - 1) begin
                    m_y = 0;
                    l_lo = p_lo; l_hi = p_hi;
                end else m_y++;
            end else m_x++;
        end else begin
            m_x = 0; m_y = 0;
            l_lo = p_lo; l_hi = p_hi;
        end
        if (wr_en_i) begin
            if (wr_addr_i == 3'd0) m_open = (wr_data_i == KEY);
            else if (m_open) begin
                if (wr_addr_i == 3'd1) begin
                    m_en = wr_data_i[0]; m_hi = wr_data_i[1]; m_vi = wr_data_i[2];
                end else begin
                    p_lo[wr_addr_i] = int'(wr_data_i[15:0]) + 1;
                    p_hi[wr_addr_i] = int'(wr_data_i[31:16]) + 1;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
        check_all(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick();
            check_all(tag);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        chk("R1", "R1", "pix_x", int'(pix_x_o), 0);
        chk("R1", "R1", "de", int'(de_o), 0);
        chk("R1", "R1", "hblank", int'(hblank_o), 1);
        chk("R1", "R1", "hsync", int'(hsync_o), 0);
        check_all("R1");
    endtask

    // R3: enable while closed must not start the counters
    task automatic t_locked();
        wr(3'd1, 32'h1, "R3");
        run(6, "R3");
        chk("R3", "R3", "pix_x", int'(pix_x_o), 0);
    endtask

    // R2 R4 R5 R6 R7: 8+2+3+2 pixels, 4+1+2+1 lines
    task automatic t_mode_a();
        wr(3'd0, KEY, "R2");
        wr(3'd2, 32'h000E_0007, "R2");
        wr(3'd3, 32'h000E_0007, "R2");
        wr(3'd4, 32'h000C_0009, "R2");
        wr(3'd5, 32'h0007_0003, "R2");
        wr(3'd6, 32'h0007_0003, "R2");
        wr(3'd7, 32'h0006_0004, "R2");
        wr(3'd1, 32'h1, "R11");
        run(245, "R2");
    endtask

    // R8 R11: both syncs inverted while running
    task automatic t_invert();
        wr(3'd1, 32'h7, "R8");
        run(130, "R8");
    endtask

    // R10: new horizontal mode written mid-frame lands at the next frame
    task automatic t_shadow();
        wr(3'd1, 32'h1, "R10");
        wr(3'd2, 32'h000B_0005, "R10");
        wr(3'd3, 32'h000B_0005, "R10");
        wr(3'd4, 32'h0008_0006, "R10");
        run(260, "R10");
    endtask

    // R3: relock, then timing and configuration writes are ignored
    task automatic t_relock();
        wr(3'd0, 32'h0000_0001, "R3");
        wr(3'd2, 32'h0005_0002, "R3");
        wr(3'd1, 32'h0, "R3");
        run(150, "R3");
    endtask

    // R9: clearing the enable bit stops and clears the counters
    task automatic t_disable();
        wr(3'd0, KEY, "R9");
        wr(3'd1, 32'h0, "R9");
        run(4, "R9");
        chk("R9", "R9", "pix_x", int'(pix_x_o), 0);
        wr(3'd1, 32'h1, "R9");
        run(40, "R9");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            p_lo[i] = 1; p_hi[i] = 1; l_lo[i] = 1; l_hi[i] = 1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_mode_a();
        t_invert();
        t_shadow();
        t_relock();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule